// File: doc/BRIEF.md
# Edge Interrupt Flag Register Bank

This block keeps sticky interrupt flags for a bank of digital inputs. Each input has a rising-edge flag and a falling-edge flag. A flag is set by a one-cycle event pulse from an upstream edge detector, but only when that input's matching enable bit is 1. A third word, the any-edge view, is the bitwise OR of the two edge words. It has no storage of its own.

Software reads the three words over a simple register port that has an address, a write strobe, write data and combinational read data. Software clears flags by writing ones. A one written to an edge word clears only that bit of that word. A one written to the any-edge word clears both edge flags of that input. When a new event and a clear reach the same bit in the same cycle, the event wins, so no edge is lost.

A summary status bit reports whether any flag is set. The interrupt request output is a registered copy of that summary. It is a level that stays high until every flag has been cleared.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset, all three flag words read 0 and both `status_o` and `irq_o` are 0.
- R2: Bit i of the rising-edge word becomes 1 after a clock edge where `rise_evt_i[i]` and `rise_en_i[i]` are both 1. An event whose enable is 0 leaves the bit unchanged.
- R3: Bit i of the falling-edge word becomes 1 after a clock edge where `fall_evt_i[i]` and `fall_en_i[i]` are both 1. An event whose enable is 0 leaves the bit unchanged.
- R4: A read at address 0x110 returns the bitwise OR of the rising-edge word and the falling-edge word.
- R5: A write to 0x110 clears every rising-edge bit and every falling-edge bit whose write-data bit is 1.
- R6: A write to 0x120 clears only the rising-edge bits whose write-data bit is 1. A write to 0x130 clears only the falling-edge bits whose write-data bit is 1. Bits written with 0 and the other edge word are unchanged.
- R7: When a set condition (R2 or R3) and a clear write hit the same bit in the same cycle, the bit ends up 1.
- R8: `status_o` is 1 exactly when any bit of the any-edge word is 1.
- R9: `irq_o` equals the value `status_o` had in the previous cycle.
- R10: A read at 0x120 returns the rising-edge word and a read at 0x130 returns the falling-edge word. A read at any other address returns 0, and a write to any other address changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rise_evt_i | input | 32 | One pulse per detected rising edge, one bit per input |
| fall_evt_i | input | 32 | One pulse per detected falling edge, one bit per input |
| rise_en_i | input | 32 | Rising-edge interrupt enables |
| fall_en_i | input | 32 | Falling-edge interrupt enables |
| bus_addr_i | input | 12 | Register byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data, where a 1 clears a flag |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| status_o | output | 1 | Any flag set |
| irq_o | output | 1 | Registered interrupt request level |

## Verification
The hardest case to reach is a clear write that lands on a bit in the same cycle as a new enabled event for that bit, particularly through the any-edge word. There the rising flag must survive while the falling flag of the same input is still cleared. Directed steps first build known flag patterns and then drive the event and the clear on the same edge. A long random phase then mixes events, enables and writes to all mapped addresses and to one unmapped address, so that partial overlaps between set and clear masks occur many times.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    parameter int NUM_IN = 32;
    parameter int ADDR_W = 12;
    parameter logic [ADDR_W-1:0] OFS_ANY  = 12'h110;
    parameter logic [ADDR_W-1:0] OFS_RISE = 12'h120;
    parameter logic [ADDR_W-1:0] OFS_FALL = 12'h130;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ANY  = 2'd1,
        SEL_RISE = 2'd2,
        SEL_FALL = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/flag_addr_decode.sv
module flag_addr_decode
    import irq_flag_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr_i,
    output reg_sel_e      sel_o
);
    always_comb begin
        unique case (addr_i)
            OFS_ANY:  sel_o = SEL_ANY;
            OFS_RISE: sel_o = SEL_RISE;
            OFS_FALL: sel_o = SEL_FALL;
            default:  sel_o = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/flag_word.sv
module flag_word #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } word_t;

    word_t word_d, word_q;

    always_comb begin
        word_d = word_q;
        // set has priority over clear on the same bit
        word_d.flags = (word_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign flags_o = word_q.flags;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i))); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((flags_o & $past(clr_i & ~set_i)) == '0)); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(flags_o)); // R6
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_flag_pkg::*;
#(
    parameter int N  = NUM_IN,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  rise_evt_i,
    input  logic [N-1:0]  fall_evt_i,
    input  logic [N-1:0]  rise_en_i,
    input  logic [N-1:0]  fall_en_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic          bus_we_i,
    input  logic [N-1:0]  bus_wdata_i,
    output logic [N-1:0]  bus_rdata_o,
    output logic          status_o,
    output logic          irq_o
);
    typedef struct packed {
        logic irq;
    } top_t;

    reg_sel_e     sel;
    logic [N-1:0] rise_set, fall_set;
    logic [N-1:0] rise_clr, fall_clr;
    logic [N-1:0] rise_flags, fall_flags, any_flags;
    top_t         top_d, top_q;

    flag_addr_decode #(.AW(AW)) u_dec (
        .addr_i (bus_addr_i),
        .sel_o  (sel)
    );

    always_comb begin
        rise_set = rise_evt_i & rise_en_i;
        fall_set = fall_evt_i & fall_en_i;
        rise_clr = '0;
        fall_clr = '0;
        if (bus_we_i) begin
            unique case (sel)
                SEL_ANY: begin
                    rise_clr = bus_wdata_i;
                    fall_clr = bus_wdata_i;
                end
                SEL_RISE: rise_clr = bus_wdata_i;
                SEL_FALL: fall_clr = bus_wdata_i;
                default: ;
            endcase
        end
    end

    flag_word #(.N(N)) u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (rise_set),
        .clr_i   (rise_clr),
        .flags_o (rise_flags)
    );

    flag_word #(.N(N)) u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (fall_set),
        .clr_i   (fall_clr),
        .flags_o (fall_flags)
    );

    assign any_flags = rise_flags | fall_flags;
    assign status_o  = |any_flags;

    always_comb begin
        top_d     = top_q;
        top_d.irq = status_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign irq_o = top_q.irq;

    always_comb begin
        unique case (sel)
            SEL_ANY:  bus_rdata_o = any_flags;
            SEL_RISE: bus_rdata_o = rise_flags;
            SEL_FALL: bus_rdata_o = fall_flags;
            default:  bus_rdata_o = '0;
        endcase
    end

    AST_RISE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rise_flags & ~$past(rise_flags) & ~$past(rise_evt_i & rise_en_i)) == '0)); // R2
    AST_FALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fall_flags & ~$past(fall_flags) & ~$past(fall_evt_i & fall_en_i)) == '0)); // R3
    AST_LINKED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && sel == SEL_ANY) |=>
        ((fall_flags & $past(bus_wdata_i & ~(fall_evt_i & fall_en_i))) == '0)); // R5
    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(status_o))); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (bus_rdata_o == '0)); // R10
endmodule

// File: tb/irq_flag_bank_bench.sv
module irq_flag_bank_bench;
    localparam int N  = 32;
    localparam int AW = 12;
    localparam logic [AW-1:0] A_ANY  = 12'h110;
    localparam logic [AW-1:0] A_RISE = 12'h120;
    localparam logic [AW-1:0] A_FALL = 12'h130;
    localparam logic [AW-1:0] A_BAD  = 12'h140;
    localparam int NV = 8;

    // stimulus table: events, enables, write strobe/address/data
    localparam logic [N-1:0] TV_RE  [NV] = '{32'h0000_00FF, 32'h0, 32'h0000_0F0F, 32'h0, 32'h0000_0001, 32'h0, 32'h8000_0000, 32'h0};
    localparam logic [N-1:0] TV_FE  [NV] = '{32'h0, 32'hFF00_0000, 32'h0, 32'h00F0_0000, 32'h0, 32'h0000_0002, 32'h0, 32'hFFFF_FFFF};
    localparam logic [N-1:0] TV_REN [NV] = '{32'h0000_000F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0000_0001, 32'h0, 32'hFFFF_FFFF, 32'h0};
    localparam logic [N-1:0] TV_FEN [NV] = '{32'h0, 32'h0F00_0000, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0000_FFFF};
    localparam logic         TV_WE  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam logic [AW-1:0] TV_AD [NV] = '{A_ANY, A_ANY, A_RISE, A_FALL, A_ANY, A_BAD, A_ANY, A_ANY};
    localparam logic [N-1:0] TV_WD  [NV] = '{32'h0, 32'h0, 32'h0000_0003, 32'h0F00_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  rise_evt, fall_evt, rise_en, fall_en, wdata, rdata;
    logic [AW-1:0] addr;
    logic          we, status, irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [N-1:0] m_rise = '0, m_fall = '0;
    logic         m_irq = 1'b0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    irq_flag_bank u_irq_flag_bank (
        .clk(clk), .rst_n(rst_n),
        .rise_evt_i(rise_evt), .fall_evt_i(fall_evt),
        .rise_en_i(rise_en), .fall_en_i(fall_en),
        .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .status_o(status), .irq_o(irq)
    );

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_all(string req);
        we = 1'b0;
        addr = A_ANY;  #1; chk({req, " R4 any-edge"}, rdata, m_rise | m_fall);
        addr = A_RISE; #1; chk({req, " R10 rise"}, rdata, m_rise);
        addr = A_FALL; #1; chk({req, " R10 fall"}, rdata, m_fall);
        addr = A_BAD;  #1; chk({req, " R10 unmapped"}, rdata, '0);
        chk({req, " R8 status"}, {31'b0, status}, {31'b0, |(m_rise | m_fall)});
        chk({req, " R9 irq"}, {31'b0, irq}, {31'b0, m_irq});
    endtask

    // drive one cycle at negedge, advance the model at the posedge
    task automatic step(logic [N-1:0] re, logic [N-1:0] fe, logic [N-1:0] ren,
                        logic [N-1:0] fen, logic w, logic [AW-1:0] a, logic [N-1:0] d);
        logic [N-1:0] cr, cf;
        rise_evt = re; fall_evt = fe; rise_en = ren; fall_en = fen;
        we = w; addr = a; wdata = d;
        cr = (w && (a == A_ANY || a == A_RISE)) ? d : '0;
        cf = (w && (a == A_ANY || a == A_FALL)) ? d : '0;
        @(posedge clk);
        m_irq  = |(m_rise | m_fall);
        m_rise = (m_rise & ~cr) | (re & ren);
        m_fall = (m_fall & ~cf) | (fe & fen);
        @(negedge clk);
        rise_evt = '0; fall_evt = '0; we = 1'b0; wdata = '0;
    endtask

    initial begin
        rise_evt = '0; fall_evt = '0; rise_en = '0; fall_en = '0;
        we = 1'b0; addr = A_ANY; wdata = '0;
        repeat (3) @(negedge clk);
        read_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        read_all("R1 after release");

        // table walk
        for (int i = 0; i < NV; i++) begin
            step(TV_RE[i], TV_FE[i], TV_REN[i], TV_FEN[i], TV_WE[i], TV_AD[i], TV_WD[i]);
            read_all("table R2 R3 R5 R6");
        end

        // R2/R3: events with enables low must not set
        step('1, '1, '0, '0, 1'b1, A_ANY, '1);
        read_all("R2 R3 gate");
        // build pattern then clear with zeros: no effect (R6)
        step(32'h0000_F0F0, 32'h0F0F_0000, '1, '1, 1'b0, A_ANY, '0);
        step('0, '0, '0, '0, 1'b1, A_RISE, '0);
        read_all("R6 zero write");
        // R6: rise clear leaves fall word alone
        step('0, 32'h0000_0010, '0, '1, 1'b1, A_RISE, 32'h0000_0010);
        read_all("R6 rise only");
        // R7: collision on an edge word
        step(32'h0000_0020, '0, '1, '0, 1'b0, A_ANY, '0);
        step(32'h0000_0020, '0, '1, '0, 1'b1, A_RISE, 32'h0000_0020);
        read_all("R7 edge collision");
        chk("R7 bit5 kept", {31'b0, m_rise[5]}, 32'h1);
        // R7 + R5: any-edge clear with a rising event: rise survives, fall cleared
        step('0, 32'h0000_0040, '0, '1, 1'b0, A_ANY, '0);
        step(32'h0000_0040, '0, '1, '0, 1'b1, A_ANY, 32'h0000_0040);
        read_all("R7 R5 linked collision");
        // R5: clear everything, irq drops one cycle later
        step('0, '0, '0, '0, 1'b1, A_ANY, '1);
        read_all("R5 full clear");
        step('0, '0, '0, '0, 1'b0, A_ANY, '0);
        read_all("R9 irq drop");

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] ra;
            logic [1:0] pick;
            pick = 2'($urandom);
            ra = (pick == 0) ? A_ANY : (pick == 1) ? A_RISE : (pick == 2) ? A_FALL : A_BAD;
            step($urandom & $urandom, $urandom & $urandom, $urandom, $urandom,
                 1'($urandom), ra, $urandom);
            read_all("random R2 R3 R5 R6 R7");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule